// File: doc/BRIEF.md
# SPI FIFO interrupt status unit

This unit is the buffering and interrupt front end of a SPI master. A register port lets software load 32-bit words into a transmit queue, pop received words from a receive queue, and program the fill levels that raise status. A shift engine on the far side pulls transmit words and pushes received words. A seven-bit status word mixes level conditions with sticky error events. A separate mask register decides which of these bits drive the single interrupt line.

Both queues are 63 words deep. A master enable bit gates the unit: while it is low, both queues are held empty and every push is discarded. Sticky bits are cleared by writing ones to the status word. Level bits follow their conditions and ignore such writes. The mask is changed only through a set-only register and a clear-only register, so software never needs a read-modify-write of the mask.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset the enable bit, the mask and the irq output are 0, both thresholds read 1, and the status word (offset 0x04) reads 0x04.
- R2: Words written to offset 0x1C while enabled come out on tx_data in write order. A tx_pop pulse while tx_avail is high advances to the next word.
- R3: Status bit 2 is 1 exactly when the transmit queue holds fewer words than the transmit threshold (offset 0x28).
- R4: Status bit 3 is 1 while the transmit queue holds 63 words. A write to 0x1C in that state is dropped and sets sticky bit 6.
- R5: rx_push stores rx_wdata. A read of offset 0x20 returns the oldest stored word and removes it. Status bit 4 is 1 while the receive queue is not empty. Bit 5 is 1 while the receive threshold (offset 0x2C) is nonzero and the receive level is at or above it.
- R6: A read of 0x20 with the receive queue empty returns 0 and leaves the queue unchanged, so the next pushed word is the next word read.
- R7: An rx_push with 63 words already stored is dropped and sets sticky bit 0.
- R8: Writing ones to offset 0x04 clears the sticky bits 0, 1 and 6. The level bits 2 to 5 are unaffected by such writes. A sticky event in the same cycle as its clear leaves the bit set.
- R9: Writing ones to offset 0x08 sets the matching mask bits. Writing ones to offset 0x0C clears them. The mask reads back at offset 0x10.
- R10: irq is 1 exactly when some status bit and its mask bit are both 1.
- R11: Bit 0 of offset 0x14 is the enable. While it is 0, both queues read as empty, and pushes are dropped without setting an overflow bit.
- R12: A cycle with fault_in high sets sticky status bit 1.
- R13: A push and a pop on the same queue in one cycle are both performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on 0x20) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from addr |
| tx_pop | input | 1 | Shift engine takes the head transmit word |
| tx_data | output | 32 | Head transmit word |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_wdata | input | 32 | Received word |
| fault_in | input | 1 | Fault indication from the bus logic |
| irq | output | 1 | Masked interrupt request |

## Verification
Two pairs of events can land in the same cycle. In the first, a software write to the transmit data offset coincides with a shift-engine pop. The bench drives both strobes in one cycle and then drains the queue; the order and count of the drained words must show that both happened. In the second, a fault pulse coincides with a write-one-to-clear of that same status bit. The bench judges it by reading the status afterwards: the bit must still be set, and a later clear alone must remove it.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned NSTAT = 7;

  localparam logic [7:0] OFF_STATUS = 8'h04;
  localparam logic [7:0] OFF_MSET   = 8'h08;
  localparam logic [7:0] OFF_MCLR   = 8'h0C;
  localparam logic [7:0] OFF_MASK   = 8'h10;
  localparam logic [7:0] OFF_ENABLE = 8'h14;
  localparam logic [7:0] OFF_TXDATA = 8'h1C;
  localparam logic [7:0] OFF_RXDATA = 8'h20;
  localparam logic [7:0] OFF_TXTHR  = 8'h28;
  localparam logic [7:0] OFF_RXTHR  = 8'h2C;

  localparam int unsigned B_RXOVF = 0;
  localparam int unsigned B_FAULT = 1;
  localparam int unsigned B_TXLOW = 2;
  localparam int unsigned B_TXFUL = 3;
  localparam int unsigned B_RXNE  = 4;
  localparam int unsigned B_RXHIT = 5;
  localparam int unsigned B_TXOVF = 6;

  localparam logic [NSTAT-1:0] STICKY = 7'b100_0011;

  // Level-driven status bits computed from queue levels and thresholds.
  function automatic logic [NSTAT-1:0] level_bits(input int unsigned txc,
                                                 input int unsigned txt,
                                                 input logic        txf,
                                                 input int unsigned rxc,
                                                 input int unsigned rxt);
    logic [NSTAT-1:0] v;
    v          = '0;
    v[B_TXLOW] = txc < txt;
    v[B_TXFUL] = txf;
    v[B_RXNE]  = rxc != 0;
    v[B_RXHIT] = (rxt != 0) && (rxc >= rxt);
    return v;
  endfunction
endpackage

// File: rtl/spi_irq_fifo.sv
module spi_irq_fifo #(
  parameter int unsigned DEPTH = 63,
  parameter int unsigned DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ovf
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = count == CW'(DEPTH);
  assign empty   = count == '0;
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf     = push && full && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] level,
  input  logic [NSTAT-1:0] set_evt,
  input  logic             clr_wr,
  input  logic             mset_wr,
  input  logic             mclr_wr,
  input  logic [NSTAT-1:0] wbits,
  output logic [NSTAT-1:0] status,
  output logic [NSTAT-1:0] mask,
  output logic             irq
);
  logic [NSTAT-1:0] sticky_q;
  logic [NSTAT-1:0] clr_bits;

  assign clr_bits = clr_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask     <= '0;
    end else begin
      // an event in the same cycle as its clear wins
      sticky_q <= ((sticky_q & ~clr_bits) | set_evt) & STICKY;
      if (mset_wr)      mask <= mask | wbits;
      else if (mclr_wr) mask <= mask & ~wbits;
    end
  end

  assign status = (sticky_q & STICKY) | (level & ~STICKY);
  assign irq    = |(status & mask);
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 63,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_data,
  output logic          tx_avail,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          fault_in,
  output logic          irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          en_q;
  logic [CW-1:0] tx_thr_q, rx_thr_q;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_ovf_evt, rx_ovf_evt;
  logic          rx_pop_req, rx_push_acc;
  logic [DW-1:0] rx_head;
  logic [NSTAT-1:0] status_w, mask_q, level_w, evt_w;

  wire wr_hit_tx  = reg_wr && (reg_addr == OFF_TXDATA);
  assign rx_pop_req  = reg_rd && (reg_addr == OFF_RXDATA);
  assign rx_push_acc = rx_push && en_q && !rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      tx_thr_q <= CW'(1);
      rx_thr_q <= CW'(1);
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_ENABLE: en_q     <= reg_wdata[0];
        OFF_TXTHR:  tx_thr_q <= reg_wdata[CW-1:0];
        OFF_RXTHR:  rx_thr_q <= reg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  spi_irq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!en_q),
    .push(wr_hit_tx), .wdata(reg_wdata[DW-1:0]),
    .pop(tx_pop), .rdata(tx_data),
    .full(tx_full), .empty(tx_empty), .count(tx_count), .ovf(tx_ovf_evt)
  );

  spi_irq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!en_q),
    .push(rx_push), .wdata(rx_wdata),
    .pop(rx_pop_req), .rdata(rx_head),
    .full(rx_full), .empty(rx_empty), .count(rx_count), .ovf(rx_ovf_evt)
  );

  assign tx_avail = !tx_empty;

  always_comb begin
    level_w = level_bits(32'(tx_count), 32'(tx_thr_q), tx_full,
                         32'(rx_count), 32'(rx_thr_q));
    evt_w          = '0;
    evt_w[B_RXOVF] = rx_ovf_evt;
    evt_w[B_FAULT] = fault_in;
    evt_w[B_TXOVF] = tx_ovf_evt;
  end

  spi_irq_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .level(level_w), .set_evt(evt_w),
    .clr_wr(reg_wr && (reg_addr == OFF_STATUS)),
    .mset_wr(reg_wr && (reg_addr == OFF_MSET)),
    .mclr_wr(reg_wr && (reg_addr == OFF_MCLR)),
    .wbits(reg_wdata[NSTAT-1:0]),
    .status(status_w), .mask(mask_q), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      OFF_STATUS: reg_rdata = 32'(status_w);
      OFF_MASK:   reg_rdata = 32'(mask_q);
      OFF_ENABLE: reg_rdata = 32'(en_q);
      OFF_RXDATA: reg_rdata = rx_empty ? '0 : 32'(rx_head);
      OFF_TXTHR:  reg_rdata = 32'(tx_thr_q);
      OFF_RXTHR:  reg_rdata = 32'(rx_thr_q);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_checks.sv
module spi_irq_checks #(
  parameter int unsigned DEPTH = 63,
  parameter int unsigned CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [6:0]    mask_q,
  input logic [6:0]    status_w,
  input logic          en_q,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_ovf_evt,
  input logic          rx_pop_req,
  input logic          rx_empty,
  input logic          rx_push_acc
);
  // R10: no interrupt can leave the block without some mask bit set
  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 7'd0));

  // R11: a cycle with the unit disabled leaves both queues empty
  a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_q) |-> (tx_count == '0) && (rx_count == '0));

  // R4: a dropped transmit push is recorded in bit 6
  a_r4_tx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_evt |=> status_w[6]);

  // R2: levels never exceed the depth
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  // R6: reading an empty receive queue changes nothing
  a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_req && rx_empty && !rx_push_acc |=> $stable(rx_count));

  // R5: data waiting in the receive queue is always reported
  a_r5_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_empty |-> status_w[4]);
endmodule

bind spi_fifo_irq_unit spi_irq_checks #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .mask_q(mask_q), .status_w(status_w),
  .en_q(en_q), .tx_count(tx_count), .rx_count(rx_count),
  .tx_ovf_evt(tx_ovf_evt), .rx_pop_req(rx_pop_req), .rx_empty(rx_empty),
  .rx_push_acc(rx_push_acc)
);

// File: tb/spi_fifo_irq_unit_test.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_test;
  localparam int DEPTH = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_pop = 1'b0;
  logic [31:0] tx_data;
  logic        tx_avail;
  logic        rx_push = 1'b0;
  logic [31:0] rx_wdata = '0;
  logic        fault_in = 1'b0;
  logic        irq;

  int ntot = 0, nbad = 0;
  bit en_m = 0;
  bit done = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [31:0] v;

  always #2.5 clk = ~clk;

  spi_fifo_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .fault_in(fault_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // driver: a write to the transmit offset, expected word queued if it fits
  task automatic tx_put(input logic [31:0] d);
    if (en_m && txq.size() < DEPTH) txq.push_back(d);
    wr(8'h1C, d);
  endtask

  // monitor: shift-engine pop, compared against the scoreboard
  task automatic tx_take(input string tag);
    logic [31:0] e;
    @(negedge clk);
    tx_pop = 1'b1;
    #1;
    e = (txq.size() != 0) ? txq.pop_front() : 32'hDEAD_0000;
    chk(tag, tx_data, e);
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic rx_in(input logic [31:0] d);
    if (en_m && rxq.size() < DEPTH) rxq.push_back(d);
    @(negedge clk);
    rx_push = 1'b1; rx_wdata = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic rx_get(input string tag);
    logic [31:0] d, e;
    e = (rxq.size() != 0) ? rxq.pop_front() : 32'h0;
    rd(8'h20, d);
    chk(tag, d, e);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      ntot++; nbad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h04, v); chk("R1 status", v, 32'h04);
    rd(8'h10, v); chk("R1 mask", v, 32'h0);
    rd(8'h14, v); chk("R1 enable", v, 32'h0);
    rd(8'h28, v); chk("R1 tx threshold", v, 32'h1);
    rd(8'h2C, v); chk("R1 rx threshold", v, 32'h1);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R11 disabled: pushes dropped, no overflow
    tx_put(32'h1111_0000);
    rx_in(32'h2222_0000);
    rd(8'h04, v); chk("R11 status while off", v, 32'h04);
    chk("R11 tx_avail while off", {31'd0, tx_avail}, 32'h0);

    wr(8'h14, 32'h1); en_m = 1;

    // R3 threshold compare
    tx_put(32'hA000_0001); tx_put(32'hA000_0002); tx_put(32'hA000_0003);
    rd(8'h04, v); chk("R3 three words thr1", v, 32'h00);
    wr(8'h28, 32'd4);
    rd(8'h04, v); chk("R3 three words thr4", v, 32'h04);
    wr(8'h28, 32'd3);
    rd(8'h04, v); chk("R3 three words thr3", v, 32'h00);

    // R2 order
    tx_take("R2 first word");
    rd(8'h04, v); chk("R3 two words thr3", v, 32'h04);

    // R13 push and pop in one cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'hA000_0004; tx_pop = 1'b1;
    #1 chk("R13 head during push+pop", tx_data, txq.pop_front());
    txq.push_back(32'hA000_0004);
    @(negedge clk);
    reg_wr = 1'b0; tx_pop = 1'b0;
    tx_take("R13 drain a");
    tx_take("R13 drain b");
    chk("R13 empty after drain", {31'd0, tx_avail}, 32'h0);
    wr(8'h28, 32'd1);

    // R4 full and overflow
    for (int i = 0; i < DEPTH; i++) tx_put(32'hB000_0000 + i);
    rd(8'h04, v); chk("R4 full", v, 32'h08);
    tx_put(32'hBAD0_BAD0);
    rd(8'h04, v); chk("R4 overflow", v, 32'h48);
    for (int i = 0; i < DEPTH; i++) tx_take("R4 drain order");
    chk("R4 dropped word absent", {31'd0, tx_avail}, 32'h0);
    rd(8'h04, v); chk("R4 sticky after drain", v, 32'h44);
    wr(8'h04, 32'h40);
    rd(8'h04, v); chk("R8 clear overflow", v, 32'h04);

    // R5 receive levels
    wr(8'h2C, 32'd3);
    rx_in(32'hC000_0001); rx_in(32'hC000_0002);
    rd(8'h04, v); chk("R5 not empty below thr", v, 32'h14);
    rx_in(32'hC000_0003);
    rd(8'h04, v); chk("R5 at thr", v, 32'h34);
    wr(8'h04, 32'h3F);
    rd(8'h04, v); chk("R8 level bits ignore clear", v, 32'h34);

    // R9 / R10 mask
    wr(8'h08, 32'h10);
    rd(8'h10, v); chk("R9 mask set", v, 32'h10);
    chk("R10 irq on rx", {31'd0, irq}, 32'h1);
    wr(8'h0C, 32'h10);
    rd(8'h10, v); chk("R9 mask clear", v, 32'h0);
    chk("R10 irq masked", {31'd0, irq}, 32'h0);
    wr(8'h08, 32'h02);
    chk("R10 irq no fault", {31'd0, irq}, 32'h0);

    // R12 fault
    @(negedge clk); fault_in = 1'b1;
    @(negedge clk); fault_in = 1'b0;
    rd(8'h04, v); chk("R12 fault sticky", v, 32'h36);
    chk("R10 irq on fault", {31'd0, irq}, 32'h1);

    // R8 event and clear in one cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h02; fault_in = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; fault_in = 1'b0;
    rd(8'h04, v); chk("R8 event beats clear", v, 32'h36);
    wr(8'h04, 32'h02);
    rd(8'h04, v); chk("R8 clear fault", v, 32'h34);
    chk("R10 irq dropped", {31'd0, irq}, 32'h0);

    // R5 pops, R6 empty read
    rx_get("R5 read 1"); rx_get("R5 read 2"); rx_get("R5 read 3");
    rx_get("R6 empty read zero");
    rx_in(32'hC000_0004);
    rx_get("R6 pointers unchanged");
    rd(8'h04, v); chk("R5 empty again", v, 32'h04);

    // R7 receive overflow
    for (int i = 0; i <= DEPTH; i++) rx_in(32'hD000_0000 + i);
    rd(8'h04, v); chk("R7 overflow", v, 32'h35);
    for (int i = 0; i < DEPTH; i++) rx_get("R7 order");
    rx_get("R7 dropped word absent");
    wr(8'h04, 32'h01);

    // R11 flush on disable
    tx_put(32'hE000_0001); rx_in(32'hE000_0002);
    wr(8'h14, 32'h0); en_m = 0; txq.delete(); rxq.delete();
    rd(8'h04, v); chk("R11 flushed status", v, 32'h04);
    wr(8'h14, 32'h1); en_m = 1;
    chk("R11 tx flushed", {31'd0, tx_avail}, 32'h0);
    rx_get("R11 rx flushed");

    done = 1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule